// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block sits behind a two-wire serial memory slave. It gathers the data bytes of one write session into a 32-byte page buffer and then stores them into the byte array in a single timed write cycle. The slave hands it four things: the starting byte address, one strobe per received data byte, a strobe at the moment the write-protect level must be sampled, and a strobe when STOP arrives. In return the block tells the slave whether data bytes may be acknowledged, and raises a busy flag that the slave uses to refuse new transfers.

The page is chosen by the upper address bits and stays fixed for the whole session. The offset inside the page advances by one for each byte and wraps at the end of the page, so later bytes replace earlier ones. A byte-valid mask records which offsets were loaded. During the commit, only those offsets are stored, and the rest of the page keeps its contents. The commit length is a parameter given in clock cycles. After reset the array is filled with FFh, and the block reports busy while it does this. A synchronous read port lets the slave fetch bytes.

Top module: `page_commit_ctrl`

## Requirements
- R1: After reset, busy_o is high for exactly 2^ADDR_W cycles while every array byte is set to 8'hFF. After that, every address reads 8'hFF.
- R2: When busy_o is low, an addr_load_i pulse opens a session. The page is taken from addr_i[ADDR_W-1:5] and the offset from addr_i[4:0]. ack_o is high from the next cycle onward.
- R3: Each byte_stb_i pulse in an open, unrejected session stores byte_i at the current offset. The offset then advances modulo 32 within the latched page, so a later byte at the same offset replaces the earlier one.
- R4: A stop_i pulse in an open, unrejected session with at least one stored byte starts a commit. busy_o goes high in the next cycle and stays high for exactly TWR_CYC cycles.
- R5: A commit writes only the offsets loaded during the session, and only inside the latched page. Every other byte of the array keeps its contents.
- R6: A wp_smp_i pulse before the first data byte, with wp_i high, rejects the session. ack_o drops in the next cycle, later bytes are discarded, STOP starts no commit, and the array is unchanged.
- R7: With wp_i low at the sample, the write proceeds. A wp_smp_i pulse after the first data byte has no effect, whatever the level of wp_i.
- R8: A stop_i pulse in a session with no stored bytes leaves busy_o low and the array unchanged.
- R9: While busy_o is high, addr_load_i, byte_stb_i, wp_smp_i and stop_i are ignored.
- R10: rd_data_o presents the array byte at rd_addr_i one clock after rd_addr_i is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| addr_load_i | input | 1 | pulse: start address valid, opens a session |
| addr_i | input | ADDR_W | starting byte address |
| byte_stb_i | input | 1 | pulse: one received data byte |
| byte_i | input | 8 | data byte |
| wp_smp_i | input | 1 | pulse: sample point for write protect |
| wp_i | input | 1 | write-protect level, high blocks writes |
| stop_i | input | 1 | pulse: STOP seen on the bus |
| ack_o | output | 1 | data bytes may be acknowledged |
| busy_o | output | 1 | initialization or commit in progress |
| mem_we_o | output | 1 | array write enable |
| mem_waddr_o | output | ADDR_W | array write address |
| mem_wdata_o | output | 8 | array write data |
| rd_addr_i | input | ADDR_W | read address |
| rd_data_o | output | 8 | read data, one cycle latency |

## Verification
The assertions assume that every strobe is a single-cycle pulse. They also assume that the slave raises stop_i only after the address load of the same session. The stimulus drives each strobe for exactly one clock between falling edges. It never raises two strobes in the same cycle, and it waits for busy_o to fall before it checks the array. The one exception is the refusal test, which deliberately drives a full session while busy_o is high to show that it has no effect.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  localparam int unsigned PAGE_BYTES = 32;
  localparam int unsigned OFS_W      = $clog2(PAGE_BYTES);

  typedef enum logic [1:0] {
    ST_INIT   = 2'd0,
    ST_IDLE   = 2'd1,
    ST_COMMIT = 2'd2
  } seq_st_e;
endpackage

// File: rtl/pcc_page_buf.sv
module pcc_page_buf
  import pcc_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  localparam int unsigned PG_W  = ADDR_W - OFS_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  busy_i,
  input  logic                  addr_load_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  byte_stb_i,
  input  logic [7:0]            byte_i,
  input  logic                  wp_smp_i,
  input  logic                  wp_i,
  input  logic                  stop_i,
  output logic                  ack_o,
  output logic                  commit_req_o,
  output logic [PG_W-1:0]       page_o,
  output logic [PAGE_BYTES-1:0] mask_o,
  input  logic [OFS_W-1:0]      rd_idx_i,
  output logic [7:0]            rd_byte_o
);
  logic                  active_q, rej_q;
  logic [OFS_W-1:0]      ptr_q;
  logic [PG_W-1:0]       page_q;
  logic [PAGE_BYTES-1:0] mask_q;
  logic [7:0]            buf_q [PAGE_BYTES];
  logic                  open_ok, wr_en;

  assign open_ok = !busy_i && active_q && !rej_q && !addr_load_i && !stop_i;
  assign wr_en   = open_ok && byte_stb_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      rej_q    <= 1'b0;
      ptr_q    <= '0;
      page_q   <= '0;
      mask_q   <= '0;
    end else if (!busy_i) begin
      if (addr_load_i) begin
        active_q <= 1'b1;
        rej_q    <= 1'b0;
        page_q   <= addr_i[ADDR_W-1:OFS_W];
        ptr_q    <= addr_i[OFS_W-1:0];
        mask_q   <= '0;
      end else if (stop_i) begin
        active_q <= 1'b0;
      end else if (wr_en) begin
        mask_q[ptr_q] <= 1'b1;
        ptr_q         <= ptr_q + 1'b1;
      end else if (open_ok && wp_smp_i && mask_q == '0) begin
        rej_q <= wp_i;
      end
    end
  end

  // data storage needs no reset: the mask qualifies every entry
  always_ff @(posedge clk_i) begin
    if (wr_en) buf_q[ptr_q] <= byte_i;
  end

  assign ack_o        = active_q && !rej_q;
  assign commit_req_o = !busy_i && stop_i && !addr_load_i && active_q && !rej_q && (mask_q != '0);
  assign page_o       = page_q;
  assign mask_o       = mask_q;
  assign rd_byte_o    = buf_q[rd_idx_i];

  // R6
  wp_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !addr_load_i && !stop_i && !byte_stb_i && wp_smp_i && wp_i && ack_o && mask_o == '0) |=> !ack_o);
  // R3
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en) |=> (ptr_q == $past(ptr_q) + 1'b1));
  // R8
  empty_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && mask_q == '0) |-> !commit_req_o);
endmodule

// File: rtl/pcc_sequencer.sv
module pcc_sequencer
  import pcc_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned TWR_CYC = 500000,
  localparam int unsigned PG_W   = ADDR_W - OFS_W,
  localparam int unsigned DEPTH  = 1 << ADDR_W,
  localparam int unsigned CNT_MX = (TWR_CYC > DEPTH) ? TWR_CYC : DEPTH,
  localparam int unsigned CNT_W  = $clog2(CNT_MX) + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  commit_req_i,
  input  logic [PG_W-1:0]       page_i,
  input  logic [PAGE_BYTES-1:0] mask_i,
  output logic [OFS_W-1:0]      rd_idx_o,
  input  logic [7:0]            rd_byte_i,
  output logic                  busy_o,
  output logic                  we_o,
  output logic [ADDR_W-1:0]     waddr_o,
  output logic [7:0]            wdata_o
);
  // TWR_CYC must be at least PAGE_BYTES: one page slot is visited per cycle
  seq_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;

  assign rd_idx_o = cnt_q[OFS_W-1:0];
  assign busy_o   = (st_q != ST_IDLE);

  always_comb begin
    we_o    = 1'b0;
    waddr_o = '0;
    wdata_o = '0;
    unique case (st_q)
      ST_INIT: begin
        we_o    = 1'b1;
        waddr_o = cnt_q[ADDR_W-1:0];
        wdata_o = 8'hFF;
      end
      ST_COMMIT: begin
        we_o    = (cnt_q < CNT_W'(PAGE_BYTES)) && mask_i[rd_idx_o];
        waddr_o = {page_i, rd_idx_o};
        wdata_o = rd_byte_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_INIT;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_INIT: begin
          if (cnt_q == CNT_W'(DEPTH - 1)) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_COMMIT: begin
          if (cnt_q == CNT_W'(TWR_CYC - 1)) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: begin
          if (commit_req_i) begin
            st_q  <= ST_COMMIT;
            cnt_q <= '0;
          end
        end
      endcase
    end
  end

  // R4
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(commit_req_i));
  // R9
  req_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_req_i |-> !busy_o);
  // R5
  we_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> busy_o);
  // R5
  we_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && st_q == ST_COMMIT) |-> (waddr_o[ADDR_W-1:OFS_W] == page_i));
endmodule

// File: rtl/pcc_array.sv
module pcc_array #(
  parameter int unsigned ADDR_W = 12,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl
  import pcc_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned TWR_CYC = 500000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_stb_i,
  input  logic [7:0]        byte_i,
  input  logic              wp_smp_i,
  input  logic              wp_i,
  input  logic              stop_i,
  output logic              ack_o,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_waddr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  localparam int unsigned PG_W = ADDR_W - OFS_W;

  logic                  commit_req;
  logic [PG_W-1:0]       page;
  logic [PAGE_BYTES-1:0] mask;
  logic [OFS_W-1:0]      rd_idx;
  logic [7:0]            rd_byte;

  pcc_page_buf #(.ADDR_W(ADDR_W)) u_buf (
    .clk_i, .rst_ni,
    .busy_i       (busy_o),
    .addr_load_i, .addr_i, .byte_stb_i, .byte_i,
    .wp_smp_i, .wp_i, .stop_i,
    .ack_o,
    .commit_req_o (commit_req),
    .page_o       (page),
    .mask_o       (mask),
    .rd_idx_i     (rd_idx),
    .rd_byte_o    (rd_byte)
  );

  pcc_sequencer #(.ADDR_W(ADDR_W), .TWR_CYC(TWR_CYC)) u_seq (
    .clk_i, .rst_ni,
    .commit_req_i (commit_req),
    .page_i       (page),
    .mask_i       (mask),
    .rd_idx_o     (rd_idx),
    .rd_byte_i    (rd_byte),
    .busy_o,
    .we_o         (mem_we_o),
    .waddr_o      (mem_waddr_o),
    .wdata_o      (mem_wdata_o)
  );

  pcc_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk_i,
    .we_i    (mem_we_o),
    .waddr_i (mem_waddr_o),
    .wdata_i (mem_wdata_o),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );
endmodule

// File: tb/page_commit_ctrl_tb.sv
module page_commit_ctrl_tb;
  localparam int AW    = 12;
  localparam int DEPTH = 1 << AW;
  localparam int TWR   = 100;

  logic          clk = 1'b0, rst_ni = 1'b0;
  logic          addr_load_i = 0, byte_stb_i = 0, wp_smp_i = 0, wp_i = 0, stop_i = 0;
  logic [AW-1:0] addr_i = '0, rd_addr_i = '0;
  logic [7:0]    byte_i = '0;
  logic          ack_o, busy_o, mem_we_o;
  logic [AW-1:0] mem_waddr_o;
  logic [7:0]    mem_wdata_o, rd_data_o;

  always #5 clk = ~clk;

  page_commit_ctrl #(.ADDR_W(AW), .TWR_CYC(TWR)) u_dut (
    .clk_i(clk), .rst_ni, .addr_load_i, .addr_i, .byte_stb_i, .byte_i,
    .wp_smp_i, .wp_i, .stop_i, .ack_o, .busy_o, .mem_we_o, .mem_waddr_o,
    .mem_wdata_o, .rd_addr_i, .rd_data_o);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model
  logic [7:0] m_mem [DEPTH];
  logic [7:0] s_buf [32];
  logic [31:0] s_mask;
  int s_page, s_ptr;
  bit s_act, s_rej;

  // scoreboard of expected reads
  typedef struct { int addr; int exp; string tag; } rd_item_t;
  rd_item_t rq[$];
  bit mon_busy = 0;

  task automatic expect_rd(int a, string tag);
    rd_item_t it;
    it.addr = a; it.exp = int'(m_mem[a]); it.tag = tag;
    rq.push_back(it);
  endtask

  initial begin
    rd_item_t it;
    forever begin
      @(negedge clk);
      if (rq.size() > 0) begin
        mon_busy = 1;
        it = rq.pop_front();
        rd_addr_i = AW'(it.addr);
        @(negedge clk);
        check(it.tag, int'(rd_data_o), it.exp);
        mon_busy = 0;
      end
    end
  end

  task automatic drain();
    do @(negedge clk); while (rq.size() > 0 || mon_busy);
  endtask

  task automatic do_load(int a);
    if (!busy_o) begin
      s_act = 1; s_rej = 0; s_page = a >> 5; s_ptr = a & 31; s_mask = '0;
    end
    @(negedge clk); addr_load_i = 1; addr_i = AW'(a);
    @(negedge clk); addr_load_i = 0;
  endtask

  task automatic do_byte(int b);
    if (!busy_o && s_act && !s_rej) begin
      s_buf[s_ptr] = 8'(b); s_mask[s_ptr] = 1'b1; s_ptr = (s_ptr + 1) % 32;
    end
    @(negedge clk); byte_stb_i = 1; byte_i = 8'(b);
    @(negedge clk); byte_stb_i = 0;
  endtask

  task automatic do_wp(bit w);
    if (!busy_o && s_act && !s_rej && s_mask == '0) s_rej = w;
    @(negedge clk); wp_smp_i = 1; wp_i = w;
    @(negedge clk); wp_smp_i = 0; wp_i = 0;
  endtask

  task automatic do_stop(string tag);
    bit was_busy, commit;
    int n;
    was_busy = busy_o;
    commit = !was_busy && s_act && !s_rej && s_mask != '0;
    if (!was_busy) s_act = 0;
    @(negedge clk); stop_i = 1;
    @(negedge clk); stop_i = 0;
    if (commit) begin
      for (int i = 0; i < 32; i++)
        if (s_mask[i]) m_mem[s_page*32 + i] = s_buf[i];
      n = 0;
      while (busy_o && n < 10*TWR) begin n++; @(negedge clk); end
      check({tag, " R4 busy length"}, n, TWR);
    end else if (!was_busy) begin
      repeat (3) begin
        check({tag, " busy stays low"}, int'(busy_o), 0);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int n;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
    s_act = 0; s_rej = 0; s_mask = '0; s_ptr = 0; s_page = 0;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", int'(busy_o), 1);
    rst_ni = 1;
    n = 0;
    while (busy_o && n < 2*DEPTH) begin n++; @(negedge clk); end
    check("R1 init length", n, DEPTH);
    check("R2 ack idle", int'(ack_o), 0);
    expect_rd(0, "R1 erased low"); expect_rd(DEPTH-1, "R1 erased high");
    expect_rd(12'h2A7, "R10 erased mid");
    drain();

    // single byte
    do_load(12'h123);
    check("R2 ack after load", int'(ack_o), 1);
    do_wp(0);
    check("R7 ack wp low", int'(ack_o), 1);
    do_byte(8'hA5);
    do_stop("single");
    expect_rd(12'h123, "R10 byte write"); expect_rd(12'h122, "R5 left neighbour");
    expect_rd(12'h124, "R5 right neighbour");
    drain();

    // page wrap with overwrite, 35 bytes starting at offset 30
    do_load(12'h05E);
    for (int i = 0; i < 35; i++) do_byte(8'h10 + i);
    do_stop("wrap");
    for (int i = 0; i < 32; i++) expect_rd(12'h040 + i, "R3 wrap page");
    expect_rd(12'h03F, "R5 below page"); expect_rd(12'h060, "R5 above page");
    drain();

    // wrap at top of array stays inside the page
    do_load(DEPTH - 2);
    for (int i = 0; i < 4; i++) do_byte(8'hC0 + i);
    do_stop("top");
    expect_rd(DEPTH - 32, "R2 page latched wrap");
    expect_rd(DEPTH - 31, "R3 top offset 1");
    expect_rd(DEPTH - 1, "R3 top last");
    expect_rd(DEPTH - 30, "R5 top untouched");
    expect_rd(0, "R2 no spill to page 0");
    drain();

    // write protect rejects
    do_load(12'h200);
    do_wp(1);
    check("R6 ack dropped", int'(ack_o), 0);
    do_byte(8'h55); do_byte(8'h66);
    do_stop("R6 rejected");
    expect_rd(12'h200, "R6 unchanged 0"); expect_rd(12'h201, "R6 unchanged 1");
    drain();

    // late wp pulse ignored
    do_load(12'h300);
    do_byte(8'h3C);
    do_wp(1);
    check("R7 ack after late wp", int'(ack_o), 1);
    do_byte(8'h4D);
    do_stop("R7 late wp");
    expect_rd(12'h300, "R7 byte0"); expect_rd(12'h301, "R7 byte1");
    drain();

    // stop with no bytes
    do_load(12'h400);
    do_stop("R8 empty");
    expect_rd(12'h400, "R8 unchanged");
    drain();

    // session during busy is ignored
    do_load(12'h123);
    do_byte(8'h5A);
    fork
      do_stop("R9 base");
      begin
        repeat (4) @(negedge clk);
        check("R9 busy during commit", int'(busy_o), 1);
        do_load(12'h500); do_byte(8'h77); do_stop("R9 ignored");
      end
    join
    check("R9 busy back low", int'(busy_o), 0);
    expect_rd(12'h500, "R9 no write"); expect_rd(12'h123, "R9 base write");
    drain();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule